// File: doc/BRIEF.md
# Flash ECC Fault Reporting Controller

This block sits next to the ECC checker of a flash array. It keeps three byte-wide registers on a simple register bus: a configuration register, an error-interrupt enable register and an error status register. On every array read strobe it looks at the single-bit and double-bit fault indications from the ECC decoder. It sets status flags, stores the faulting address and data in capture registers, and drives level interrupts for command completion and for each fault type.

Software can inject faults for testing. Two force bits make every array read set the corresponding status flag, but the capture registers still change only when the decoder reports a real fault. A separate ignore bit turns off reporting of real single-bit faults. The command-complete condition comes in as a flag from the command sequencer.

Top module: `flash_ecc_fault_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all three interrupt outputs are low.
- R2: The configuration register at offset 0x4 holds command-complete enable in bit 7, ignore-single in bit 4, force-double in bit 1 and force-single in bit 0. Bits 6, 5, 3 and 2 always read 0 and writes to them are dropped, so writing 0xFF reads back as 0x93.
- R3: `irq_cmd` is high exactly while `cmd_done` is high and configuration bit 7 is 1.
- R4: While ignore-single is 1, a real single-bit fault on a read does not set the single flag and does not load the capture registers.
- R5: While force-double is 1, every read strobe sets the double flag (status bit 1). While it is 0, only a real double-bit fault sets that flag.
- R6: While force-single is 1, every read strobe sets the single flag (status bit 0), even when ignore-single is 1. While it is 0, only a real, unignored single-bit fault sets that flag.
- R7: A read with no real fault never changes the capture registers, whatever the force bits are. A read with a real reported fault loads the read address and the read data.
- R8: Force bits keep their value across any number of reads until software writes them.
- R9: The error-interrupt enable register at offset 0x5 holds the single enable in bit 0 and the double enable in bit 1. `irq_sbf` equals status bit 0 AND enable bit 0, and `irq_dbf` equals status bit 1 AND enable bit 1.
- R10: The status register sits at offset 0x6. Writing 1 to a flag bit clears that flag. If a write of 1 and a set event come in the same cycle, the flag stays set.
- R11: The capture registers read byte-wise from offset 0x8 upward: the address bytes least significant first, then the data bytes least significant first (0x8, 0x9 address; 0xA, 0xB data with default widths).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | REG_AW | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| rd_strobe | input | 1 | One array read completes this cycle |
| rd_addr | input | ADDR_W | Address of the array read |
| rd_data | input | DATA_W | Data returned by the array read |
| sbf_in | input | 1 | Decoder reports a single-bit fault for this read |
| dbf_in | input | 1 | Decoder reports a double-bit fault for this read |
| cmd_done | input | 1 | Command-complete flag from the command sequencer |
| irq_cmd | output | 1 | Command-complete interrupt request |
| irq_sbf | output | 1 | Single-bit fault interrupt request |
| irq_dbf | output | 1 | Double-bit fault interrupt request |

## Verification
The hardest case to reach from the ports is a read where a forced flag and a real fault mix. For example, force-double is set while the decoder reports a real single-bit fault, or force-single is set while ignore-single is also set. In these cases the flag outcome and the capture outcome follow different rules. The vector table walks each mix of force, ignore and fault inputs. Each read uses a distinct address and data value, so a capture that should not have happened shows up as a changed byte. A second corner needs a status write of 1 in the same cycle as a read strobe that sets the flag. The bench drives both in one clock cycle.

// File: rtl/flash_ecc_fault_ctrl.sv
module flash_ecc_fault_ctrl #(
  parameter int REG_AW = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              sbf_in,
  input  logic              dbf_in,
  input  logic              cmd_done,
  output logic              irq_cmd,
  output logic              irq_sbf,
  output logic              irq_dbf
);
  localparam int CAP_W     = ADDR_W + DATA_W;
  localparam int CAP_BYTES = (CAP_W + 7) / 8;
  localparam int CAP_BASE  = 8;
  localparam logic [REG_AW-1:0] OFS_CFG  = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFS_IEN  = REG_AW'(5);
  localparam logic [REG_AW-1:0] OFS_STAT = REG_AW'(6);

  logic cc_en, ign_s, frc_d, frc_s;
  logic en_s, en_d;
  logic flag_s, flag_d;
  logic [CAP_BYTES*8-1:0] cap;

  wire wr_cfg  = bus_wr && bus_addr == OFS_CFG;
  wire wr_ien  = bus_wr && bus_addr == OFS_IEN;
  wire wr_stat = bus_wr && bus_addr == OFS_STAT;

  wire real_s = sbf_in && !ign_s;
  wire set_s  = rd_strobe && (real_s || frc_s);
  wire set_d  = rd_strobe && (dbf_in || frc_d);
  wire load   = rd_strobe && (dbf_in || real_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cc_en, ign_s, frc_d, frc_s} <= '0;
      {en_s, en_d}                 <= '0;
    end else begin
      if (wr_cfg) {cc_en, ign_s, frc_d, frc_s} <= {bus_wdata[7], bus_wdata[4], bus_wdata[1], bus_wdata[0]};
      if (wr_ien) {en_d, en_s} <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_s <= 1'b0;
      flag_d <= 1'b0;
    end else begin
      if (set_s) flag_s <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_s <= 1'b0;
      if (set_d) flag_d <= 1'b1;
      else if (wr_stat && bus_wdata[1]) flag_d <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap <= '0;
    else if (load) cap <= (CAP_BYTES*8)'({rd_data, rd_addr});
  end

  always_comb begin
    bus_rdata = 8'h00;
    unique case (bus_addr)
      OFS_CFG:  bus_rdata = {cc_en, 2'b00, ign_s, 2'b00, frc_d, frc_s};
      OFS_IEN:  bus_rdata = {6'b0, en_d, en_s};
      OFS_STAT: bus_rdata = {6'b0, flag_d, flag_s};
      default: begin
        for (int i = 0; i < CAP_BYTES; i++)
          if (int'(bus_addr) == CAP_BASE + i) bus_rdata = cap[8*i +: 8];
      end
    endcase
  end

  assign irq_cmd = cmd_done && cc_en;
  assign irq_sbf = flag_s && en_s;
  assign irq_dbf = flag_d && en_d;

  assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == OFS_CFG |-> bus_rdata[6:5] == 2'b00 && bus_rdata[3:2] == 2'b00);

  assert_ignore_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && sbf_in && !dbf_in && ign_s && !frc_s && !flag_s |=> !flag_s);

  assert_force_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && frc_d |=> flag_d);

  assert_force_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && frc_s |=> flag_s);

  assert_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && (sbf_in || dbf_in)) |=> $stable(cap));

  assert_force_persist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frc_s && !wr_cfg |=> frc_s);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_d && wr_stat && bus_wdata[1] |=> flag_d);
endmodule

// File: tb/tb_flash_ecc_fault_ctrl.sv
module tb_flash_ecc_fault_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data = '0;
  logic        sbf_in = 1'b0, dbf_in = 1'b0, cmd_done = 1'b0;
  logic        irq_cmd, irq_sbf, irq_dbf;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  flash_ecc_fault_ctrl dut (.*);

  // {force_s, force_d, ignore, sbf, dbf, exp_flag_s, exp_flag_d, exp_capture}
  localparam logic [7:0] VEC [10] = '{
    8'b00010101, 8'b00001011, 8'b00000000, 8'b00110000, 8'b10000100,
    8'b01000010, 8'b11000110, 8'b10100100, 8'b01010111, 8'b00011111
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic array_read(logic [15:0] a, logic [15:0] d, logic s, logic db);
    @(negedge clk);
    rd_strobe = 1'b1; rd_addr = a; rd_data = d; sbf_in = s; dbf_in = db;
    @(negedge clk);
    rd_strobe = 1'b0; sbf_in = 1'b0; dbf_in = 1'b0;
  endtask

  function automatic logic [31:0] cap_word(logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r, b0, b1, b2, b3;
    logic [31:0] exp_cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 4; a < 12; a++) begin
      rd(4'(a), r);
      check("R1 reset regs", {24'b0, r}, 32'h0);
    end
    check("R1 reset irqs", {29'b0, irq_cmd, irq_sbf, irq_dbf}, 32'h0);

    // R11 capture layout + R7 table walk
    exp_cap = 32'h0;
    foreach (VEC[i]) begin
      logic [7:0] v;
      logic [15:0] ad, da;
      v = VEC[i];
      ad = 16'h1200 + 16'(i);
      da = 16'hA500 + 16'(i * 3);
      wr(4'h4, {3'b000, v[5], 2'b00, v[6], v[7]});
      wr(4'h6, 8'h03);
      array_read(ad, da, v[4], v[3]);
      rd(4'h6, r);
      check("R4/R5/R6 flags", {30'b0, r[1:0]}, {30'b0, v[1], v[2]});
      if (v[0]) exp_cap = {da, ad};
      rd(4'h8, b0); rd(4'h9, b1); rd(4'hA, b2); rd(4'hB, b3);
      check("R7/R11 capture", cap_word(b0, b1, b2, b3), exp_cap);
    end
    wr(4'h4, 8'h00);

    // R2 reserved bits
    wr(4'h4, 8'hFF);
    rd(4'h4, r);
    check("R2 cfg readback", {24'b0, r}, 32'h93);
    wr(4'h4, 8'h00);

    // R3 command-complete interrupt
    @(negedge clk); cmd_done = 1'b1; #1;
    check("R3 irq_cmd disabled", {31'b0, irq_cmd}, 32'h0);
    wr(4'h4, 8'h80);
    #1 check("R3 irq_cmd enabled", {31'b0, irq_cmd}, 32'h1);
    @(negedge clk); cmd_done = 1'b0; #1;
    check("R3 irq_cmd drop", {31'b0, irq_cmd}, 32'h0);
    wr(4'h4, 8'h00);

    // R8 force persistence
    wr(4'h4, 8'h03);
    array_read(16'h1, 16'h2, 1'b0, 1'b0);
    array_read(16'h3, 16'h4, 1'b0, 1'b0);
    rd(4'h4, r);
    check("R8 force bits persist", {24'b0, r}, 32'h03);
    wr(4'h4, 8'h00);
    rd(4'h4, r);
    check("R8 force bits cleared by write", {24'b0, r}, 32'h00);

    // R9 interrupt gating
    wr(4'h6, 8'h03);
    array_read(16'h5, 16'h6, 1'b1, 1'b1);
    #1 check("R9 irqs masked", {30'b0, irq_sbf, irq_dbf}, 32'h0);
    wr(4'h5, 8'h01);
    #1 check("R9 single enabled", {30'b0, irq_sbf, irq_dbf}, 32'h2);
    wr(4'h5, 8'h02);
    #1 check("R9 double enabled", {30'b0, irq_sbf, irq_dbf}, 32'h1);

    // R10 clear vs set
    @(negedge clk);
    bus_addr = 4'h6; bus_wdata = 8'h03; bus_wr = 1'b1;
    rd_strobe = 1'b1; dbf_in = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rd_strobe = 1'b0; dbf_in = 1'b0;
    rd(4'h6, r);
    check("R10 set wins over clear", {30'b0, r[1:0]}, 32'h2);
    wr(4'h6, 8'h02);
    rd(4'h6, r);
    check("R10 write one clears", {30'b0, r[1:0]}, 32'h0);
    #1 check("R9 irq drops with flag", {31'b0, irq_dbf}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule